// File: doc/BRIEF.md
# Exception Entry Controller

This block sits beside the fetch and execute stages of a 32-bit in-order core that has branch delay slots. Every exception source raises its own request line. The controller picks one request when several arrive in the same cycle. One clock later it presents the handler's redirect address together with write strobes and values for four registers: the exception program counter, the exception effective address, the saved status and the new status. The status register itself lives outside the block. The block reads it to find the vector half (low or high base) and the two enable bits that gate the asynchronous sources.

The saved program counter depends on the class of the winning exception. Faults point back at the faulting instruction. A system call points at the instruction after the caller. Tick and external interrupts save the current PC and move fetch straight to the handler. In each case the value is reduced by 4 when the instruction sits in a delay slot, so that the branch is replayed. Tick and external interrupt requests are latched until their enable bit allows them to be taken. Synchronous requests belong to instructions that the redirect flushes. They are honoured only in the cycle in which they are raised.

Top module: `exc_entry_ctrl`

## Requirements
- R1: While rst_n is low, and after it is released with no request, redir_valid_o, epcr_we_o, eear_we_o, esr_we_o and sr_we_o are all 0.
- R2: Request bit n of req_i stands for cause index n. The indices are: reset 1, bus error 2, data page fault 3, instruction page fault 4, tick 5, alignment 6, illegal 7, external interrupt 8, data TLB miss 9, instruction TLB miss 10, range 11, system call 12, trap 14. One clock after a request is accepted, redir_valid_o pulses for one cycle. In that cycle cause_o holds the index, redir_pc_o holds index*0x100 plus 0xF000_0000 when sr_i bit 14 was set (plus 0 otherwise), and next_pc_o holds redir_pc_o + 4.
- R3: When several requests are eligible in the same cycle, the winner is taken in this order: reset, instruction TLB miss, instruction page fault, bus error, illegal, alignment, data TLB miss, data page fault, range, system call, trap, tick, external interrupt.
- R4: For bus error, both page faults, alignment, illegal, both TLB misses, range and trap, epcr_o holds pc_i, or pc_i − 4 when dslot_i was set, with the result taken modulo 2^32.
- R5: For a system call, epcr_o holds pc_i + 4, or pc_i when dslot_i was set.
- R6: For tick and external interrupt, epcr_o holds pc_i, or pc_i − 4 when dslot_i was set.
- R7: A reset request leaves epcr_we_o at 0. It still pulses eear_we_o, esr_we_o and sr_we_o.
- R8: On every entry, eear_o holds the sampled ea_i and esr_o holds the sampled sr_i. sr_o holds sr_i with bit 0 (supervisor) set and with bit 1 (tick enable) and bit 2 (interrupt enable) cleared.
- R9: A tick request seen while sr_i bit 1 is 0 produces no entry. It is latched and taken once, in the first cycle in which bit 1 is 1 and no higher request wins. After that it does not fire again.
- R10: An external interrupt request seen while sr_i bit 2 is 0 produces no entry. It is latched and taken once, in the first cycle in which bit 2 is 1 and no higher request wins.
- R11: In the cycle in which redir_valid_o is high, every request except reset is ignored for the following entry, and synchronous requests raised in that cycle are discarded. Request bits 0 and 13 never cause an entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 15 | Per-cause request lines, bit n = cause index n |
| ea_i | input | 32 | Faulting effective address |
| pc_i | input | 32 | Address of the current instruction |
| dslot_i | input | 1 | Current instruction is in a delay slot |
| sr_i | input | 32 | Current status register |
| redir_valid_o | output | 1 | Fetch redirect strobe |
| redir_pc_o | output | 32 | Handler address |
| next_pc_o | output | 32 | Handler address + 4 |
| cause_o | output | 4 | Index of the cause taken |
| epcr_we_o | output | 1 | Exception PC write strobe |
| epcr_o | output | 32 | Exception PC value |
| eear_we_o | output | 1 | Effective address write strobe |
| eear_o | output | 32 | Effective address value |
| esr_we_o | output | 1 | Saved status write strobe |
| esr_o | output | 32 | Saved status value |
| sr_we_o | output | 1 | New status write strobe |
| sr_o | output | 32 | New status value |

## Verification
The bench builds the controller with its default parameters: 32-bit addresses and 0xF000_0000 as the high vector base. With a 32-bit width, a delay-slot fault at PC 0 must wrap to 0xFFFF_FFFC, and the high base adds to the code without overlapping it. One stimulus raises system call, trap, tick and interrupt together. This checks the priority order, and it also shows that the losing asynchronous causes stay latched and come out one after another in later entries while the losing trap is dropped.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

    localparam int NUM_REQ  = 15;
    localparam int IDX_W    = 4;
    localparam int NUM_PRIO = 13;

    localparam int CX_RESET   = 1;
    localparam int CX_BUSERR  = 2;
    localparam int CX_DPF     = 3;
    localparam int CX_IPF     = 4;
    localparam int CX_TICK    = 5;
    localparam int CX_ALIGN   = 6;
    localparam int CX_ILLEGAL = 7;
    localparam int CX_EXTINT  = 8;
    localparam int CX_DTLB    = 9;
    localparam int CX_ITLB    = 10;
    localparam int CX_RANGE   = 11;
    localparam int CX_SYSCALL = 12;
    localparam int CX_TRAP    = 14;

    localparam int SRB_SUPV = 0;
    localparam int SRB_TEN  = 1;
    localparam int SRB_IEN  = 2;
    localparam int SRB_HIGH = 14;

    typedef enum logic [1:0] {
        EPC_FAULT,
        EPC_NEXT,
        EPC_ASYNC,
        EPC_NONE
    } epc_kind_e;

    // Priority slot s (0 = highest) to cause index
    function automatic int prio_slot(input int s);
        case (s)
            0:       return CX_RESET;
            1:       return CX_ITLB;
            2:       return CX_IPF;
            3:       return CX_BUSERR;
            4:       return CX_ILLEGAL;
            5:       return CX_ALIGN;
            6:       return CX_DTLB;
            7:       return CX_DPF;
            8:       return CX_RANGE;
            9:       return CX_SYSCALL;
            10:      return CX_TRAP;
            11:      return CX_TICK;
            default: return CX_EXTINT;
        endcase
    endfunction

    function automatic epc_kind_e epc_kind(input logic [IDX_W-1:0] idx);
        case (int'(idx))
            CX_RESET:          return EPC_NONE;
            CX_SYSCALL:        return EPC_NEXT;
            CX_TICK, CX_EXTINT: return EPC_ASYNC;
            default:           return EPC_FAULT;
        endcase
    endfunction

endpackage

// File: rtl/exc_prio_arb.sv
module exc_prio_arb
    import exc_entry_pkg::*;
(
    input  logic [NUM_REQ-1:0] elig_i,
    output logic               any_o,
    output logic [IDX_W-1:0]   idx_o
);

    logic [NUM_PRIO-1:0] slot_hit;

    generate
        for (genvar s = 0; s < NUM_PRIO; s++) begin : g_slot
            assign slot_hit[s] = elig_i[prio_slot(s)];
        end
    endgenerate

    always_comb begin
        any_o = 1'b0;
        idx_o = '0;
        for (int s = NUM_PRIO - 1; s >= 0; s--) begin
            if (slot_hit[s]) begin
                any_o = 1'b1;
                idx_o = IDX_W'(prio_slot(s));
            end
        end
    end

    // R3
    always_comb begin
        if (any_o) begin
            grant_eligible_chk: assert (elig_i[idx_o]);
        end
    end

endmodule

// File: rtl/exc_vec_gen.sv
module exc_vec_gen
    import exc_entry_pkg::*;
#(
    parameter int                ADDR_W    = 32,
    parameter logic [ADDR_W-1:0] HIGH_BASE = 32'hF000_0000
) (
    input  logic [IDX_W-1:0]  idx_i,
    input  logic              high_i,
    output logic [ADDR_W-1:0] vec_o,
    output logic [ADDR_W-1:0] npc_o
);

    localparam int CODE_W = IDX_W + 8;

    logic [ADDR_W-1:0] code;

    always_comb begin
        code  = ADDR_W'({idx_i, 8'h00});
        vec_o = code + (high_i ? HIGH_BASE : '0);
        npc_o = vec_o + ADDR_W'(4);
    end

    initial begin
        width_fit_chk: assert (CODE_W <= ADDR_W);
    end

endmodule

// File: rtl/exc_epc_calc.sv
module exc_epc_calc
    import exc_entry_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  epc_kind_e         kind_i,
    input  logic [ADDR_W-1:0] pc_i,
    input  logic              dslot_i,
    output logic              we_o,
    output logic [ADDR_W-1:0] epc_o
);

    logic [ADDR_W-1:0] base;

    always_comb begin
        base  = (kind_i == EPC_NEXT) ? pc_i + ADDR_W'(4) : pc_i;
        epc_o = dslot_i ? base - ADDR_W'(4) : base;
        we_o  = (kind_i != EPC_NONE);
    end

endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
    import exc_entry_pkg::*;
#(
    parameter int                ADDR_W    = 32,
    parameter logic [ADDR_W-1:0] HIGH_BASE = 32'hF000_0000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_REQ-1:0] req_i,
    input  logic [ADDR_W-1:0]  ea_i,
    input  logic [ADDR_W-1:0]  pc_i,
    input  logic               dslot_i,
    input  logic [ADDR_W-1:0]  sr_i,
    output logic               redir_valid_o,
    output logic [ADDR_W-1:0]  redir_pc_o,
    output logic [ADDR_W-1:0]  next_pc_o,
    output logic [IDX_W-1:0]   cause_o,
    output logic               epcr_we_o,
    output logic [ADDR_W-1:0]  epcr_o,
    output logic               eear_we_o,
    output logic [ADDR_W-1:0]  eear_o,
    output logic               esr_we_o,
    output logic [ADDR_W-1:0]  esr_o,
    output logic               sr_we_o,
    output logic [ADDR_W-1:0]  sr_o
);

    typedef struct packed {
        logic              valid;
        logic [IDX_W-1:0]  cause;
        logic [ADDR_W-1:0] pc;
        logic [ADDR_W-1:0] npc;
        logic              epcr_we;
        logic [ADDR_W-1:0] epcr;
        logic [ADDR_W-1:0] eear;
        logic [ADDR_W-1:0] esr;
        logic [ADDR_W-1:0] sr;
        logic              tick_pend;
        logic              int_pend;
    } ent_state_t;

    ent_state_t st_d, st_q;

    logic [NUM_REQ-1:0] elig;
    logic               win_any;
    logic [IDX_W-1:0]   win_idx;
    logic [ADDR_W-1:0]  vec, vec_npc, epc;
    logic               epc_we;
    logic               tick_seen, int_seen;

    always_comb begin
        tick_seen = st_q.tick_pend | req_i[CX_TICK];
        int_seen  = st_q.int_pend  | req_i[CX_EXTINT];
        elig              = req_i;
        elig[CX_TICK]     = tick_seen & sr_i[SRB_TEN];
        elig[CX_EXTINT]   = int_seen  & sr_i[SRB_IEN];
        if (st_q.valid) begin
            elig           = '0;
            elig[CX_RESET] = req_i[CX_RESET];
        end
    end

    exc_prio_arb u_arb (
        .elig_i (elig),
        .any_o  (win_any),
        .idx_o  (win_idx)
    );

    exc_vec_gen #(
        .ADDR_W    (ADDR_W),
        .HIGH_BASE (HIGH_BASE)
    ) u_vec (
        .idx_i  (win_idx),
        .high_i (sr_i[SRB_HIGH]),
        .vec_o  (vec),
        .npc_o  (vec_npc)
    );

    exc_epc_calc #(
        .ADDR_W (ADDR_W)
    ) u_epc (
        .kind_i  (epc_kind(win_idx)),
        .pc_i    (pc_i),
        .dslot_i (dslot_i),
        .we_o    (epc_we),
        .epc_o   (epc)
    );

    always_comb begin
        st_d         = st_q;
        st_d.valid   = 1'b0;
        st_d.epcr_we = 1'b0;
        if (win_any) begin
            st_d.valid   = 1'b1;
            st_d.cause   = win_idx;
            st_d.pc      = vec;
            st_d.npc     = vec_npc;
            st_d.epcr_we = epc_we;
            st_d.epcr    = epc;
            st_d.eear    = ea_i;
            st_d.esr     = sr_i;
            st_d.sr      = sr_i;
            st_d.sr[SRB_SUPV] = 1'b1;
            st_d.sr[SRB_TEN]  = 1'b0;
            st_d.sr[SRB_IEN]  = 1'b0;
        end
        st_d.tick_pend = tick_seen & ~(win_any && int'(win_idx) == CX_TICK);
        st_d.int_pend  = int_seen  & ~(win_any && int'(win_idx) == CX_EXTINT);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign redir_valid_o = st_q.valid;
    assign redir_pc_o    = st_q.pc;
    assign next_pc_o     = st_q.npc;
    assign cause_o       = st_q.cause;
    assign epcr_we_o     = st_q.epcr_we;
    assign epcr_o        = st_q.epcr;
    assign eear_we_o     = st_q.valid;
    assign eear_o        = st_q.eear;
    assign esr_we_o      = st_q.valid;
    assign esr_o         = st_q.esr;
    assign sr_we_o       = st_q.valid;
    assign sr_o          = st_q.sr;

    // R11
    one_shot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        redir_valid_o |=> (!redir_valid_o || int'(cause_o) == CX_RESET));

    // R2
    npc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        redir_valid_o |-> next_pc_o == redir_pc_o + ADDR_W'(4));

    // R7
    epcr_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        redir_valid_o |-> (epcr_we_o == (int'(cause_o) != CX_RESET)));

    // R8
    saved_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        redir_valid_o |-> (esr_o == $past(sr_i) && eear_o == $past(ea_i)));

    // R9
    tick_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (redir_valid_o && int'(cause_o) == CX_TICK) |-> $past(sr_i[SRB_TEN]));

    // R10
    int_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (redir_valid_o && int'(cause_o) == CX_EXTINT) |-> $past(sr_i[SRB_IEN]));

endmodule

// File: tb/tb_exc_entry_ctrl.sv
module tb_exc_entry_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [14:0] req = '0;
    logic [31:0] ea = '0, pc = '0, sr = '0;
    logic        ds = 1'b0;
    logic        rv, epw, eaw, esw, srw;
    logic [31:0] rpc, npc, epcr, eear, esr, srn;
    logic [3:0]  cause;

    int nvec = 0;
    int nerr = 0;
    bit done = 0;

    always #4 clk = ~clk;

    exc_entry_ctrl dut (
        .clk(clk), .rst_n(rst_n), .req_i(req), .ea_i(ea), .pc_i(pc),
        .dslot_i(ds), .sr_i(sr), .redir_valid_o(rv), .redir_pc_o(rpc),
        .next_pc_o(npc), .cause_o(cause), .epcr_we_o(epw), .epcr_o(epcr),
        .eear_we_o(eaw), .eear_o(eear), .esr_we_o(esw), .esr_o(esr),
        .sr_we_o(srw), .sr_o(srn)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] vec_of(input int idx, input logic [31:0] s);
        return (32'(idx) << 8) + (s[14] ? 32'hF000_0000 : 32'h0);
    endfunction

    function automatic logic [31:0] sr_new(input logic [31:0] s);
        return (s | 32'h1) & ~32'h6;
    endfunction

    // checks an entry at the current negedge
    task automatic chk_entry(input string r, input int idx, input logic [31:0] exp_epc,
                             input bit exp_epw, input logic [31:0] s, input logic [31:0] a);
        chk({r, " valid"}, 32'(rv), 32'd1);
        chk({r, " cause"}, 32'(cause), 32'(idx));
        chk({r, " vector R2"}, rpc, vec_of(idx, s));
        chk({r, " next_pc R2"}, npc, vec_of(idx, s) + 32'd4);
        chk({r, " epcr_we"}, 32'(epw), 32'(exp_epw));
        if (exp_epw) chk({r, " epcr"}, epcr, exp_epc);
        chk({r, " eear R8"}, eear, a);
        chk({r, " esr R8"}, esr, s);
        chk({r, " sr R8"}, srn, sr_new(s));
        chk({r, " strobes R8"}, {29'd0, eaw, esw, srw}, 32'h7);
    endtask

    task automatic chk_idle(input string r);
        chk({r, " no entry"}, 32'(rv), 32'd0);
    endtask

    // drive one request cycle, check at the next negedge, clear, pass the blocked cycle
    task automatic shot(input string r, input logic [14:0] rq, input logic [31:0] p,
                        input bit d, input logic [31:0] a, input logic [31:0] s,
                        input int idx, input logic [31:0] exp_epc, input bit exp_epw);
        req = rq; pc = p; ds = d; ea = a; sr = s;
        @(negedge clk);
        chk_entry(r, idx, exp_epc, exp_epw, s, a);
        req = '0;
        @(negedge clk);
        chk_idle({r, " blocked cycle R11"});
    endtask

    task automatic t_reset;
        chk("R1 valid in reset", 32'(rv), 32'd0);
        chk("R1 strobes in reset", {27'd0, epw, eaw, esw, srw, rv}, 32'd0);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        chk("R1 valid after reset", 32'(rv), 32'd0);
        chk("R1 strobes after reset", {27'd0, epw, eaw, esw, srw, rv}, 32'd0);
    endtask

    task automatic t_faults;
        shot("R4 itlb", 15'(1 << 10), 32'h1000, 0, 32'hDEAD_0000, 32'h6, 10, 32'h1000, 1);
        shot("R4 align dslot high", 15'(1 << 6), 32'h2008, 1, 32'h1234_5678, 32'h4000, 6, 32'h2004, 1);
        shot("R4 trap", 15'(1 << 14), 32'h0040, 0, 32'h0, 32'h2, 14, 32'h0040, 1);
        shot("R4 wrap dpf", 15'(1 << 3), 32'h0, 1, 32'h55, 32'h0, 3, 32'hFFFF_FFFC, 1);
    endtask

    task automatic t_syscall;
        shot("R5 syscall", 15'(1 << 12), 32'h0300, 0, 32'h0, 32'h6, 12, 32'h0304, 1);
        shot("R5 syscall dslot", 15'(1 << 12), 32'h0300, 1, 32'h0, 32'h4006, 12, 32'h0300, 1);
    endtask

    task automatic t_reset_req;
        shot("R7 reset req", 15'(1 << 1), 32'h0888, 0, 32'h77, 32'h6, 1, 32'h0, 0);
    endtask

    task automatic t_priority;
        shot("R3 all sync with reset", 15'h5FDE & ~15'(1 << 5) & ~15'(1 << 8),
             32'h10, 0, 32'h0, 32'h0, 1, 32'h0, 0);
        shot("R3 itlb over rest", 15'h5EDC & ~15'(1 << 8), 32'h10, 0, 32'h0, 32'h0, 10, 32'h10, 1);
        shot("R3 buserr over illegal", 15'((1 << 2) | (1 << 7) | (1 << 12)),
             32'h20, 0, 32'h0, 32'h0, 2, 32'h20, 1);
        // syscall beats trap, tick, int; losing async causes stay latched (R9 R10)
        req = 15'((1 << 12) | (1 << 14) | (1 << 5) | (1 << 8));
        pc = 32'h400; ds = 0; ea = 32'h9; sr = 32'h6;
        @(negedge clk);
        chk_entry("R3 syscall over trap/async", 12, 32'h404, 1, 32'h6, 32'h9);
        req = '0;
        @(negedge clk); chk_idle("R11 blocked after syscall");
        @(negedge clk);
        chk_entry("R3 R9 held tick next", 5, 32'h400, 1, 32'h6, 32'h9);
        @(negedge clk); chk_idle("R11 blocked after tick");
        @(negedge clk);
        chk_entry("R3 R10 held int last", 8, 32'h400, 1, 32'h6, 32'h9);
        @(negedge clk); chk_idle("R11 blocked after int");
        @(negedge clk); chk_idle("R11 trap dropped");
    endtask

    task automatic t_tick_mask;
        req = 15'(1 << 5); pc = 32'h600; ds = 1; ea = 32'h0; sr = 32'h0;
        @(negedge clk); chk_idle("R9 masked tick");
        req = '0;
        @(negedge clk); chk_idle("R9 still masked");
        sr = 32'h2;
        @(negedge clk);
        chk_entry("R6 R9 tick taken dslot", 5, 32'h5FC, 1, 32'h2, 32'h0);
        @(negedge clk); chk_idle("R9 blocked");
        @(negedge clk); chk_idle("R9 tick not repeated");
    endtask

    task automatic t_int_mask;
        sr = 32'h2;
        req = 15'(1 << 8); pc = 32'h700; ds = 0; ea = 32'h44;
        @(negedge clk); chk_idle("R10 masked int");
        req = '0;
        @(negedge clk); chk_idle("R10 still masked");
        sr = 32'h4004;
        @(negedge clk);
        chk_entry("R6 R10 int taken high", 8, 32'h700, 1, 32'h4004, 32'h44);
        @(negedge clk); chk_idle("R10 blocked");
        @(negedge clk); chk_idle("R10 int not repeated");
    endtask

    task automatic t_block;
        sr = 32'h0; pc = 32'h800; ds = 0; ea = 32'h0;
        req = 15'(1 << 2);
        @(negedge clk);
        chk_entry("R11 first", 2, 32'h800, 1, 32'h0, 32'h0);
        req = 15'(1 << 7);
        @(negedge clk); chk_idle("R11 illegal in busy cycle ignored");
        req = '0;
        @(negedge clk); chk_idle("R11 illegal dropped");
        req = 15'(1 << 9);
        @(negedge clk);
        chk_entry("R11 dtlb", 9, 32'h800, 1, 32'h0, 32'h0);
        req = 15'(1 << 1);
        @(negedge clk);
        chk_entry("R11 reset in busy cycle", 1, 32'h0, 0, 32'h0, 32'h0);
        req = 15'(1 << 0) | 15'(1 << 13);
        @(negedge clk); chk_idle("R11 bits 0/13 during busy");
        @(negedge clk); chk_idle("R11 bits 0/13 ignored");
        req = '0;
        @(negedge clk); chk_idle("R11 idle");
    endtask

    initial begin
        t_reset();
        t_faults();
        t_syscall();
        t_reset_req();
        t_priority();
        t_tick_mask();
        t_int_mask();
        t_block();
        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            nerr++;
            $display("FAIL watchdog expired");
            $display("  == %0d vectors applied, %0d miscompares ==", nvec, nerr);
            $finish;
        end
    end

endmodule